// File: doc/BRIEF.md
# Per-Channel Dual Threshold Alarm Unit

This unit keeps an upper and a lower limit for each of up to sixteen converter channels. Every conversion result arrives from the sequencer as a channel number and a data word. The unit checks the result only against the two limits of that channel. It raises separate over-limit and under-limit flags, and it drives one combined active-high alarm pin.

The limits are loaded through command words that the sequencer passes on one frame at a time. An entry word opens a programming sequence and carries the upper two bits of the channel number. Each programming word that follows carries the lower two bits, a high/low select, a continue/exit bit and the limit value. Results are still checked while a sequence is open, so conversion continues without a break.

Top module: `alarm_unit`

## Requirements
- R1: After reset every high limit is all ones (full scale) and every low limit is zero. All three alarm outputs are low, and no result value on any channel raises an alarm until limits are written.
- R2: `alarm_hi_o` is 1 after a result strictly greater than the high limit of its own channel. A result equal to the limit gives 0.
- R3: `alarm_lo_o` is 1 after a result strictly less than the low limit of its own channel. A result equal to the limit gives 0.
- R4: `alarm_o` is the OR of the two flags and is active high. All flags are registered: they update on the clock edge that takes a valid result. They hold their value until the next valid result.
- R5: A frame with bits [15:12] = 4'b1011, taken while no sequence is open, opens a programming sequence. Its bits [1:0] become the upper channel bits bb.
- R6: Inside a sequence, each frame writes a limit. The target channel is {bb, bits[15:14]}. Bit 13 selects the high limit when 1 and the low limit when 0. The limit value is taken from bits [11:0].
- R7: A programming frame with bit 12 = 0 keeps the sequence open, with the same bb, for the next frame. With bit 12 = 1 the frame still writes, and later frames are not treated as programming frames until a new entry frame arrives.
- R8: A frame that arrives while no sequence is open and is not an entry frame changes no limit.
- R9: Results are checked while a sequence is open. A result in the same cycle as a write to its channel is checked against the old limit. Results in later cycles use the new limit.
- R10: A write to one channel's limit leaves the limits of all other channels, and the other limit of the same channel, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_valid_i | input | 1 | A command frame is present this cycle |
| frame_i | input | 16 | Command frame word |
| res_valid_i | input | 1 | A conversion result is present this cycle |
| res_chan_i | input | 4 | Channel of the result |
| res_data_i | input | 12 | Conversion result |
| alarm_o | output | 1 | Combined alarm, active high |
| alarm_hi_o | output | 1 | Last result was above its high limit |
| alarm_lo_o | output | 1 | Last result was below its low limit |

## Verification
The comparison is tried with results one code above, equal to, and one code below each programmed limit. This separates strict from inclusive comparisons. Results on neighbouring and unprogrammed channels at full scale and zero show whether writes leak across channels, and whether the reset limits stay silent. A write and a result on the same channel in the same cycle, followed by a repeat of that result, separate old-limit from new-limit use. A non-entry frame sent after an exit frame shows whether the sequence really closed. If it did not, that frame would load a tiny limit into a channel the bench then reads.

// File: rtl/alarm_unit_pkg.sv
package alarm_unit_pkg;
  localparam int FRAME_W = 16;
  localparam int CHAN_W  = 4;
  localparam logic [3:0] ENTRY_CODE = 4'b1011;

  typedef enum logic {ST_IDLE, ST_PROG} prog_state_e;
endpackage

// File: rtl/alarm_prog_ctrl.sv
module alarm_prog_ctrl
  import alarm_unit_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               wr_en_o,
  output logic               wr_hi_o,
  output logic [CHAN_W-1:0]  wr_chan_o,
  output logic [RES_W-1:0]   wr_val_o
);
  prog_state_e state_q;
  logic [1:0]  bb_q;
  logic        is_entry;
  logic        exit_bit;

  assign is_entry = frame_i[15:12] == ENTRY_CODE;
  assign exit_bit = frame_i[12];

  always_comb begin
    wr_en_o   = frame_valid_i && (state_q == ST_PROG);
    wr_hi_o   = frame_i[13];
    wr_chan_o = {bb_q, frame_i[15:14]};
    wr_val_o  = frame_i[RES_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bb_q    <= '0;
    end else if (frame_valid_i) begin
      case (state_q)
        ST_IDLE: if (is_entry) begin
          state_q <= ST_PROG;
          bb_q    <= frame_i[1:0];
        end
        ST_PROG: if (exit_bit) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_entry_opens_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && frame_valid_i && is_entry) |=> (state_q == ST_PROG && bb_q == $past(frame_i[1:0])));
  assert_exit_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && frame_valid_i && exit_bit) |=> state_q == ST_IDLE);
  assert_continue_keeps_bb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && frame_valid_i && !exit_bit) |=> (state_q == ST_PROG && $stable(bb_q)));
  assert_foreign_frame_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && frame_valid_i && !is_entry) |=> state_q == ST_IDLE);
endmodule

// File: rtl/alarm_thr_bank.sv
module alarm_thr_bank
  import alarm_unit_pkg::*;
#(
  parameter int CH_N  = 16,
  parameter int RES_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_hi_i,
  input  logic [CHAN_W-1:0] wr_chan_i,
  input  logic [RES_W-1:0]  wr_val_i,
  input  logic [CHAN_W-1:0] rd_chan_i,
  output logic [RES_W-1:0]  rd_hi_o,
  output logic [RES_W-1:0]  rd_lo_o
);
  logic [CH_N-1:0][RES_W-1:0] hi_q;
  logic [CH_N-1:0][RES_W-1:0] lo_q;

  for (genvar c = 0; c < CH_N; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q[c] <= '1;
        lo_q[c] <= '0;
      end else if (wr_en_i && (int'(wr_chan_i) == c)) begin
        if (wr_hi_i) hi_q[c] <= wr_val_i;
        else         lo_q[c] <= wr_val_i;
      end
    end
  end

  // Channels beyond CH_N read as never-alarming limits
  always_comb begin
    rd_hi_o = '1;
    rd_lo_o = '0;
    for (int c = 0; c < CH_N; c++) begin
      if (int'(rd_chan_i) == c) begin
        rd_hi_o = hi_q[c];
        rd_lo_o = lo_q[c];
      end
    end
  end

  assert_no_stray_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(hi_q) && $stable(lo_q)));
  assert_high_select_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_hi_i) |=> $stable(lo_q));
  assert_low_select_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_hi_i) |=> $stable(hi_q));
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp #(
  parameter int RES_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_data_i,
  input  logic [RES_W-1:0] hi_thr_i,
  input  logic [RES_W-1:0] lo_thr_i,
  output logic             over_o,
  output logic             under_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_o  <= 1'b0;
      under_o <= 1'b0;
    end else if (res_valid_i) begin
      over_o  <= res_data_i > hi_thr_i;
      under_o <= res_data_i < lo_thr_i;
    end
  end

  assert_flags_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> ($stable(over_o) && $stable(under_o)));
  assert_full_scale_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && hi_thr_i == '1) |=> !over_o);
  assert_zero_floor_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && lo_thr_i == '0) |=> !under_o);
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
  import alarm_unit_pkg::*;
#(
  parameter int CH_N  = 16,
  parameter int RES_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_valid_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               res_valid_i,
  input  logic [CHAN_W-1:0]  res_chan_i,
  input  logic [RES_W-1:0]   res_data_i,
  output logic               alarm_o,
  output logic               alarm_hi_o,
  output logic               alarm_lo_o
);
  logic              wr_en, wr_hi;
  logic [CHAN_W-1:0] wr_chan;
  logic [RES_W-1:0]  wr_val, hi_thr, lo_thr;

  alarm_prog_ctrl #(.RES_W(RES_W)) u_ctrl (
    .clk_i, .rst_ni, .frame_valid_i, .frame_i,
    .wr_en_o(wr_en), .wr_hi_o(wr_hi), .wr_chan_o(wr_chan), .wr_val_o(wr_val)
  );

  alarm_thr_bank #(.CH_N(CH_N), .RES_W(RES_W)) u_bank (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_hi_i(wr_hi), .wr_chan_i(wr_chan), .wr_val_i(wr_val),
    .rd_chan_i(res_chan_i), .rd_hi_o(hi_thr), .rd_lo_o(lo_thr)
  );

  alarm_cmp #(.RES_W(RES_W)) u_cmp (
    .clk_i, .rst_ni, .res_valid_i, .res_data_i,
    .hi_thr_i(hi_thr), .lo_thr_i(lo_thr),
    .over_o(alarm_hi_o), .under_o(alarm_lo_o)
  );

  assign alarm_o = alarm_hi_o | alarm_lo_o;

  assert_alarm_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_i |=> $stable(alarm_o));
endmodule

// File: tb/sim_alarm_unit.sv
`timescale 1ns/1ps
module sim_alarm_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0;
  logic [15:0] frame = '0;
  logic        rv = 1'b0;
  logic [3:0]  rch = '0;
  logic [11:0] rdat = '0;
  logic        alarm, a_hi, a_lo;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  alarm_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_valid_i(fv), .frame_i(frame),
    .res_valid_i(rv), .res_chan_i(rch), .res_data_i(rdat),
    .alarm_o(alarm), .alarm_hi_o(a_hi), .alarm_lo_o(a_lo)
  );

  // {channel, result, expected over, expected under}; limits: ch6 800/100, ch7 400/000
  localparam logic [17:0] VEC [9] = '{
    {4'd6, 12'h801, 1'b1, 1'b0},
    {4'd6, 12'h800, 1'b0, 1'b0},
    {4'd6, 12'h0FF, 1'b0, 1'b1},
    {4'd6, 12'h100, 1'b0, 1'b0},
    {4'd7, 12'h401, 1'b1, 1'b0},
    {4'd7, 12'h400, 1'b0, 1'b0},
    {4'd7, 12'h000, 1'b0, 1'b0},
    {4'd5, 12'hFFF, 1'b0, 1'b0},
    {4'd6, 12'h500, 1'b0, 1'b0}
  };

  task automatic check3(string tag, logic [2:0] exp);
    checks++;
    if ({alarm, a_hi, a_lo} !== exp) begin
      errors++;
      $display("FAIL %s actual={alarm,hi,lo}=%b expected=%b", tag, {alarm, a_hi, a_lo}, exp);
    end
  endtask

  task automatic send_frame(logic [15:0] f);
    @(negedge clk); fv = 1'b1; frame = f;
    @(negedge clk); fv = 1'b0;
  endtask

  task automatic result(string tag, logic [3:0] ch, logic [11:0] d, logic h, logic l);
    @(negedge clk); rv = 1'b1; rch = ch; rdat = d;
    @(negedge clk); rv = 1'b0;
    check3(tag, {h | l, h, l});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check3("R1 reset outputs", 3'b000);
    result("R1 full scale quiet", 4'd3, 12'hFFF, 1'b0, 1'b0);
    result("R1 zero quiet", 4'd9, 12'h000, 1'b0, 1'b0);

    // R5/R6/R7: bb=01, ch6 hi 800, ch6 lo 100, ch7 hi 400 with exit
    send_frame(16'hB001);
    send_frame(16'hA800);
    send_frame(16'h8100);
    send_frame(16'hF400);
    // R8: non-entry frame after exit; would hit ch4 hi=005 if still open
    send_frame(16'h2005);
    result("R8 R7 ch4 untouched after exit", 4'd4, 12'h010, 1'b0, 1'b0);

    for (int i = 0; i < 9; i++) begin
      result($sformatf("R2 R3 R6 R10 vector %0d", i), VEC[i][17:14], VEC[i][13:2], VEC[i][1], VEC[i][0]);
    end

    // R4: flags hold without new result
    result("R4 set over flag", 4'd6, 12'hA00, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check3("R4 hold over idle cycles", 3'b110);
    send_frame(16'h0000);
    check3("R4 hold across frame", 3'b110);

    // R9: write and result same cycle on ch1
    send_frame(16'hB000);
    result("R9 result during open sequence", 4'd2, 12'hFFF, 1'b0, 1'b0);
    @(negedge clk); fv = 1'b1; frame = 16'h6010; rv = 1'b1; rch = 4'd1; rdat = 12'h020;
    @(negedge clk); fv = 1'b0; rv = 1'b0;
    check3("R9 same-cycle uses old limit", 3'b000);
    result("R9 later cycle uses new limit", 4'd1, 12'h020, 1'b1, 1'b0);
    send_frame(16'h5030);
    result("R2 R3 both flags ch1", 4'd1, 12'h020, 1'b1, 1'b1);
    result("R10 ch0 unaffected", 4'd0, 12'h020, 1'b0, 1'b0);

    // R1: reset restores defaults
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check3("R1 outputs in reset", 3'b000);
    rst_n = 1'b1;
    result("R1 ch6 limits restored", 4'd6, 12'h801, 1'b0, 1'b0);
    result("R1 ch1 low restored", 4'd1, 12'h000, 1'b0, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule